// File: doc/BRIEF.md
# Multicycle Five-Instruction Processor Core

This block is a 32-bit processor that runs a small load/store instruction subset: register-register arithmetic, OR with an immediate, word load, word store and branch-on-equal. Each instruction is broken into short steps, one per clock. Every instruction is fetched and then decoded. It then passes through one to three further steps that depend on its class. Values pass between steps through internal holding registers: the instruction word, two operand latches, an ALU result latch and a memory data latch.

Instructions and data share a single word-addressed memory port, so the core makes at most one access per cycle. A write is committed at the rising clock edge. Read data must reflect the presented address within the same cycle. The register file, the step sequencer and the program counter are all inside the block. The program counter is a byte address, and the port carries the word address taken from its bits [ADDR_W+1:2].

Top module: `mc_core`

## Requirements
- R1: While `rst` is high, `memWe` is low and `memAddr` is 0; the first cycle after reset is a fetch from word 0 with PC = 0, and every register of the file starts at 0.
- R2: The first two cycles of every instruction (fetch, then decode) present the PC word address with `memWe` low; the fetched word is latched, and the operands are read from the registers named by bits [25:21] (rs) and [20:16] (rt).
- R3: Opcode 0x00 (bits [31:26]) takes 4 cycles and writes to register rd (bits [15:11]) a result chosen by bits [5:0]: 0x20 add, 0x22 subtract rs-rt, 0x24 AND, 0x25 OR, 0x2A signed less-than (1 or 0); any other code writes 0.
- R4: Opcode 0x0D takes 4 cycles and writes rs OR the zero-extended bits [15:0] into rt.
- R5: Opcode 0x23 takes 5 cycles; its fourth cycle presents the word address of rs + sign-extended bits [15:0] with `memWe` low, and the word read there is written into rt.
- R6: Opcode 0x2B takes 4 cycles; in its fourth cycle, and only then, `memWe` is high for one cycle, `memAddr` is the word address of rs + sign-extended bits [15:0] and `memWdata` is the value of rt.
- R7: Opcode 0x04 takes 3 cycles; the next PC is PC+4 + (sign-extended bits [15:0] shifted left by 2) when rs equals rt, and PC+4 otherwise.
- R8: Register 0 always reads as 0; writes to it are dropped.
- R9: Any other opcode takes 3 cycles, changes no register and no memory word, and advances PC by 4.
- R10: `memWe` is low in every cycle except the store cycle of R6; a data access uses the ALU result latch as its address.
- R11: After the last step of an instruction the next cycle is a fetch, and PC changes only in that last step. The step codes are: fetch 0000, decode 0001, skip 0010, branch 0011, register execute 0100, register write 0101, immediate OR 0110, immediate write 0111, load address 1000, load read 1001, load write 1010, store address 1011 and store write 1100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | ADDR_W | Word address of the current memory access |
| memWdata | output | 32 | Store data (value of rt) |
| memWe | output | 1 | Write strobe, committed at the next rising edge |
| memRdata | input | 32 | Word at `memAddr`, valid within the same cycle |

## Verification
The assertions assume that `rst` is high from time zero and that the memory returns the addressed word combinationally in the cycle the address is shown. They also assume that no other agent writes memory while the core runs. The bench holds reset from the start and models the memory as an array that is read directly from `memAddr` and written at the clock edge. Its generated programs keep every data address word-aligned and inside a data region that is separate from the code. The programs end in a branch-to-self, so fetches never leave the loaded code.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int XLEN = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_IDX_W = $clog2(REG_COUNT);

  // step codes; the values are part of the block's behaviour
  typedef enum logic [3:0] {
    ST_FETCH  = 4'b0000,
    ST_DECODE = 4'b0001,
    ST_SKIP   = 4'b0010,
    ST_BEQ    = 4'b0011,
    ST_RX     = 4'b0100,
    ST_RWB    = 4'b0101,
    ST_OX     = 4'b0110,
    ST_OWB    = 4'b0111,
    ST_LADR   = 4'b1000,
    ST_LMEM   = 4'b1001,
    ST_LWB    = 4'b1010,
    ST_SADR   = 4'b1011,
    ST_SMEM   = 4'b1100
  } mcState_t;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_SLT  = 3'd4,
    ALU_ZERO = 3'd5
  } aluOp_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic   irLoad;
    logic   abLoad;
    logic   sLoad;
    logic   mLoad;
    aluOp_t aluOp;
    logic   aluSrcImm;
    logic   immSigned;
    logic   memWrite;
    logic   memUseS;
    logic   regWrite;
    logic   regDstRd;
    logic   regFromMem;
    logic   pcStep;
    logic   pcBranch;
  } ctrlStrobes_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluOp_t       op,
  output logic [W-1:0] result
);

  always_comb begin
    case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  // entry 0 is hard-wired to zero on the read side
  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      ctrl,
  input  logic [XLEN-1:0]   memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [XLEN-1:0]   memWdata,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  output logic [XLEN-1:0]   pcOut
);

  localparam int IMM_W = 16;
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] pcReg, irReg, aReg, bReg, sReg, mReg;
  logic [XLEN-1:0] rfA, rfB, immExt, aluB, aluOut;
  logic [XLEN-1:0] pcPlus4, branchTarget, wrData;
  logic [REG_IDX_W-1:0] rsIdx, rtIdx, rdIdx, wrIdx;

  assign opcode = irReg[31:26];
  assign rsIdx  = irReg[25:21];
  assign rtIdx  = irReg[20:16];
  assign rdIdx  = irReg[15:11];
  assign funct  = irReg[5:0];

  assign immExt = ctrl.immSigned ? {{EXT_W{irReg[IMM_W-1]}}, irReg[IMM_W-1:0]}
                                 : {{EXT_W{1'b0}}, irReg[IMM_W-1:0]};
  assign aluB   = ctrl.aluSrcImm ? immExt : bReg;

  assign pcPlus4      = pcReg + XLEN'(4);
  assign branchTarget = pcPlus4 + {{(EXT_W-2){irReg[IMM_W-1]}}, irReg[IMM_W-1:0], 2'b00};

  assign wrIdx  = ctrl.regDstRd ? rdIdx : rtIdx;
  assign wrData = ctrl.regFromMem ? mReg : sReg;

  mc_regfile #(.W(XLEN), .NREG(REG_COUNT)) regFile (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wrIdx),
    .wrData  (wrData),
    .rdDataA (rfA),
    .rdDataB (rfB)
  );

  mc_alu #(.W(XLEN)) alu (
    .opA    (aReg),
    .opB    (aluB),
    .op     (ctrl.aluOp),
    .result (aluOut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg <= '0;
      irReg <= '0;
      aReg  <= '0;
      bReg  <= '0;
      sReg  <= '0;
      mReg  <= '0;
    end else begin
      if (ctrl.irLoad) irReg <= memRdata;
      if (ctrl.abLoad) begin
        aReg <= rfA;
        bReg <= rfB;
      end
      if (ctrl.sLoad) sReg <= aluOut;
      if (ctrl.mLoad) mReg <= memRdata;
      if (ctrl.pcBranch) pcReg <= (aReg == bReg) ? branchTarget : pcPlus4;
      else if (ctrl.pcStep) pcReg <= pcPlus4;
    end
  end

  assign memAddr  = ctrl.memUseS ? sReg[ADDR_W+1:2] : pcReg[ADDR_W+1:2];
  assign memWdata = bReg;
  assign pcOut    = pcReg;

endmodule

// File: rtl/mc_control.sv
module mc_control
  import mc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  output ctrlStrobes_t ctrl,
  output mcState_t     stateOut
);

  mcState_t state, nextState;
  aluOp_t   functOp;

  always_comb begin
    case (funct)
      FN_ADD:  functOp = ALU_ADD;
      FN_SUB:  functOp = ALU_SUB;
      FN_AND:  functOp = ALU_AND;
      FN_OR:   functOp = ALU_OR;
      FN_SLT:  functOp = ALU_SLT;
      default: functOp = ALU_ZERO;
    endcase
  end

  always_comb begin
    ctrl      = '0;
    nextState = ST_FETCH;
    case (state)
      ST_FETCH: begin
        ctrl.irLoad = 1'b1;
        nextState   = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl.abLoad = 1'b1;
        case (opcode)
          OP_RTYPE: nextState = ST_RX;
          OP_ORI:   nextState = ST_OX;
          OP_LW:    nextState = ST_LADR;
          OP_SW:    nextState = ST_SADR;
          OP_BEQ:   nextState = ST_BEQ;
          default:  nextState = ST_SKIP;
        endcase
      end
      ST_SKIP: ctrl.pcStep = 1'b1;
      ST_BEQ:  ctrl.pcBranch = 1'b1;
      ST_RX: begin
        ctrl.sLoad = 1'b1;
        ctrl.aluOp = functOp;
        nextState  = ST_RWB;
      end
      ST_RWB: begin
        ctrl.regWrite = 1'b1;
        ctrl.regDstRd = 1'b1;
        ctrl.pcStep   = 1'b1;
      end
      ST_OX: begin
        ctrl.sLoad     = 1'b1;
        ctrl.aluOp     = ALU_OR;
        ctrl.aluSrcImm = 1'b1;
        nextState      = ST_OWB;
      end
      ST_OWB: begin
        ctrl.regWrite = 1'b1;
        ctrl.pcStep   = 1'b1;
      end
      ST_LADR, ST_SADR: begin
        ctrl.sLoad     = 1'b1;
        ctrl.aluOp     = ALU_ADD;
        ctrl.aluSrcImm = 1'b1;
        ctrl.immSigned = 1'b1;
        nextState      = (state == ST_LADR) ? ST_LMEM : ST_SMEM;
      end
      ST_LMEM: begin
        ctrl.mLoad   = 1'b1;
        ctrl.memUseS = 1'b1;
        nextState    = ST_LWB;
      end
      ST_LWB: begin
        ctrl.regWrite   = 1'b1;
        ctrl.regFromMem = 1'b1;
        ctrl.pcStep     = 1'b1;
      end
      ST_SMEM: begin
        ctrl.memWrite = 1'b1;
        ctrl.memUseS  = 1'b1;
        ctrl.pcStep   = 1'b1;
      end
      default: nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

  assign stateOut = state;

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [XLEN-1:0]   memWdata,
  output logic              memWe,
  input  logic [XLEN-1:0]   memRdata
);

  ctrlStrobes_t    ctrlBus;
  mcState_t        curState;
  logic [5:0]      opcode, funct;
  logic [XLEN-1:0] pcValue;

  mc_control control (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .funct    (funct),
    .ctrl     (ctrlBus),
    .stateOut (curState)
  );

  mc_datapath #(.ADDR_W(ADDR_W)) datapath (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrlBus),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode),
    .funct    (funct),
    .pcOut    (pcValue)
  );

  assign memWe = ctrlBus.memWrite;

endmodule

// File: rtl/mc_core_checker.sv
module mc_core_checker
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input mcState_t          state,
  input logic [XLEN-1:0]   pc,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  logic lastStep;
  assign lastStep = state inside {ST_SKIP, ST_BEQ, ST_RWB, ST_OWB, ST_LWB, ST_SMEM};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && state == ST_FETCH && !memWe));

  // R2
  fetch_port_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> (memAddr == pc[ADDR_W+1:2] && !memWe));

  // R2
  decode_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  // R11
  return_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    lastStep |=> (state == ST_FETCH));

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lastStep |=> $stable(pc));

  // R10
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (state == ST_SMEM));

  // R6
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |=> !memWe);

endmodule

bind mc_core mc_core_checker #(.ADDR_W(ADDR_W)) coreChk (
  .clk     (clk),
  .rst     (rst),
  .state   (curState),
  .pc      (pcValue),
  .memWe   (memWe),
  .memAddr (memAddr)
);

// File: tb/mc_core_test.sv
module mc_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int MEM_WORDS  = 1024;
  localparam int DATA_BASE  = 512;
  localparam int HALT_SLOT  = 480;
  localparam int RUN_CYCLES = 12000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic memWe;

  logic [31:0] mem  [MEM_WORDS];
  logic [31:0] gmem [MEM_WORDS];
  logic [31:0] gregs [32];
  string       gtag [32];
  logic [31:0] gpc;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core #(.ADDR_W(ADDR_W)) uut (
    .clk      (clk),
    .rst      (rst),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRdata (memRdata)
  );

  assign memRdata = mem[memAddr[9:0]];
  always @(posedge clk) if (memWe) mem[memAddr[9:0]] <= memWdata;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] refAlu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic put(int slot, logic [31:0] word);
    mem[slot]  = word;
    gmem[slot] = word;
  endtask

  task automatic randMemOperand(output int base, output logic [15:0] imm);
    if ($urandom % 2 == 0) begin
      base = 0;
      imm  = 16'(32'h800 + 4 * ($urandom % 512));
    end else begin
      base = 29;
      imm  = 16'(4 * ($urandom % 512) - 1024);
    end
  endtask

  task automatic buildProgram();
    int base;
    logic [15:0] imm;
    logic [5:0] fn;
    // directed corner cases
    put(0,  encI(6'h0D, 0, 29, 16'h0C00));
    put(1,  encI(6'h0D, 0, 1, 16'h8001));       // R4 zero extension
    put(2,  encI(6'h2B, 0, 1, 16'h0800));
    put(3,  encI(6'h0D, 0, 0, 16'hFFFF));       // R8 write to r0
    put(4,  encI(6'h2B, 0, 0, 16'h0804));
    put(5,  encR(0, 1, 2, 6'h22));              // negative result
    put(6,  encR(2, 1, 3, 6'h2A));              // signed compare
    put(7,  encI(6'h2B, 29, 2, 16'hFFFC));      // negative offset
    put(8,  encI(6'h2B, 0, 3, 16'h0808));
    put(9,  encI(6'h04, 1, 1, 16'h0001));       // R7 taken
    put(10, encI(6'h0D, 0, 4, 16'h1234));       // skipped
    put(11, encI(6'h2B, 0, 4, 16'h080C));
    put(12, encI(6'h04, 1, 2, 16'h0001));       // R7 not taken
    put(13, encI(6'h3F, 1, 5, 16'h00FF));       // R9 unknown opcode
    put(14, encR(1, 2, 6, 6'h07));              // unknown function code
    put(15, encI(6'h23, 29, 7, 16'hFFFC));      // R5 negative offset
    put(16, encI(6'h2B, 0, 7, 16'h0810));
    put(17, encI(6'h2B, 0, 6, 16'h0814));
    for (int i = 18; i < HALT_SLOT; i++) begin
      int kind;
      kind = int'($urandom % 100);
      if (kind < 30) begin
        case ($urandom % 6)
          0: fn = 6'h20;
          1: fn = 6'h22;
          2: fn = 6'h24;
          3: fn = 6'h25;
          4: fn = 6'h2A;
          default: fn = 6'h07;
        endcase
        put(i, encR(int'($urandom % 30), int'($urandom % 30), 1 + int'($urandom % 28), fn));
      end else if (kind < 45) begin
        put(i, encI(6'h0D, int'($urandom % 30), 1 + int'($urandom % 28), 16'($urandom)));
      end else if (kind < 60) begin
        randMemOperand(base, imm);
        put(i, encI(6'h23, base, 1 + int'($urandom % 28), imm));
      end else if (kind < 80) begin
        randMemOperand(base, imm);
        put(i, encI(6'h2B, base, int'($urandom % 29), imm));
      end else if (kind < 93) begin
        int rs, rt, off;
        rs  = int'($urandom % 8);
        rt  = ($urandom % 4 == 0) ? rs : int'($urandom % 8);
        off = int'($urandom % 7);
        if (i + 1 + off > HALT_SLOT) off = HALT_SLOT - i - 1;
        put(i, encI(6'h04, rs, rt, 16'(off)));
      end else begin
        put(i, encI(($urandom % 2 == 0) ? 6'h3F : 6'h02, int'($urandom % 30), int'($urandom % 30), 16'($urandom)));
      end
    end
    put(HALT_SLOT, encI(6'h04, 0, 0, 16'hFFFF));  // branch to self
  endtask

  task automatic refWrite(int r, logic [31:0] v, string tag);
    if (r != 0) begin
      gregs[r] = v;
      gtag[r]  = tag;
    end
  endtask

  task automatic runOne(inout string fetchTag);
    logic [31:0] ins, a, b, ea;
    logic [5:0] op;
    int rs, rt, rd, n;
    bit isLw, isSw;
    ins  = gmem[gpc[11:2]];
    op   = ins[31:26];
    rs   = int'(ins[25:21]);
    rt   = int'(ins[20:16]);
    rd   = int'(ins[15:11]);
    a    = gregs[rs];
    b    = gregs[rt];
    ea   = a + {{16{ins[15]}}, ins[15:0]};
    isLw = (op == 6'h23);
    isSw = (op == 6'h2B);
    n    = (op == 6'h00 || op == 6'h0D || isSw) ? 4 : (isLw ? 5 : 3);
    for (int c = 0; c < n; c++) begin
      if (c == 0) begin
        check(memAddr == gpc[ADDR_W+1:2] && !memWe, fetchTag, 32'(memAddr), gpc >> 2);
      end else if (c == 1) begin
        check(memAddr == gpc[ADDR_W+1:2] && !memWe, "R2", 32'(memAddr), gpc >> 2);
      end else if (isSw && c == 3) begin
        check(memWe === 1'b1 && memAddr == ea[ADDR_W+1:2], "R6", 32'(memAddr), ea >> 2);
        check(memWdata == b, gtag[rt], memWdata, b);
      end else if (isLw && c == 3) begin
        check(!memWe && memAddr == ea[ADDR_W+1:2], "R5", 32'(memAddr), ea >> 2);
      end else begin
        check(!memWe, "R10", 32'(memWe), 32'd0);
      end
      @(negedge clk);
      cyc++;
    end
    fetchTag = "R11";
    case (op)
      6'h00: begin refWrite(rd, refAlu(ins[5:0], a, b), "R3"); gpc = gpc + 4; end
      6'h0D: begin refWrite(rt, a | {16'h0, ins[15:0]}, "R4"); gpc = gpc + 4; end
      6'h23: begin refWrite(rt, gmem[ea[11:2]], "R5"); gpc = gpc + 4; end
      6'h2B: begin gmem[ea[11:2]] = b; gpc = gpc + 4; end
      6'h04: begin
        gpc = (a == b) ? gpc + 4 + {{14{ins[15]}}, ins[15:0], 2'b00} : gpc + 4;
        fetchTag = "R7";
      end
      default: begin gpc = gpc + 4; fetchTag = "R9"; end
    endcase
  endtask

  initial begin
    string fetchTag;
    void'($urandom(32'd7321));
    for (int i = 0; i < 32; i++) begin
      gregs[i] = '0;
      gtag[i]  = "R1";
    end
    gtag[0] = "R8";
    for (int i = 0; i < MEM_WORDS; i++) begin
      logic [31:0] w;
      w = (i >= DATA_BASE) ? $urandom : 32'd0;
      mem[i]  = w;
      gmem[i] = w;
    end
    buildProgram();
    gpc = '0;
    repeat (3) @(negedge clk);
    check(!memWe && memAddr == '0, "R1", 32'(memAddr), 32'd0);
    rst = 1'b0;
    fetchTag = "R1";
    while (cyc < RUN_CYCLES) runOne(fetchTag);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule